// File: doc/BRIEF.md
# VCO Tank Band Search Controller

This controller picks one of eight oscillator tank bands for a frequency synthesizer. A start request loads a caller-supplied starting band onto the 3-bit tank output and begins a search. After every band change the controller waits a programmable number of system clocks, so that the loop can settle. It then reads two flags from the synthesizer: a lock flag and a tuning-voltage direction flag.

A set lock flag ends the search with a one-cycle done pulse, and the band then stays fixed. When the lock flag is clear, the direction flag selects the next band. Low means the tuning voltage is under range, and the search moves to the adjacent lower band. High means it is over range, and the search moves to the adjacent higher band. The search stops with a fail flag in two cases: a step would leave the eight-band range, or the search turns around more often than the reversal budget allows.

The state machine has five states:
- `ST_IDLE` waits for a start.
- `ST_SETTLE` runs the settle timer and moves to `ST_CHECK` when the timer expires.
- `ST_CHECK` samples the flags. It moves to `ST_LOCKED` on lock, to `ST_FAIL` on a range or reversal violation, and back to `ST_SETTLE` after a one-band step.
- `ST_LOCKED` and `ST_FAIL` hold their results.

A start request moves every state to `ST_SETTLE`.

Top module: `vco_band_search`

## Requirements
- R1: During and after reset, with no start request, the tank output is 000, done is 0 and fail is 0.
- R2: A start request sampled at a clock edge places the initial code on the tank output after that edge, clears fail, and restarts the search even when a search is already running.
- R3: After each tank change (including the load on start), the flags are not acted on until at least `settle_cycles_i` clock cycles have passed.
- R4: When the lock flag is 1 at the sample point, the direction flag is ignored, the tank code is kept and done is raised.
- R5: Lock 0 with direction 0 (under range) moves the tank code down by one; code 000 is the lowest-frequency band.
- R6: Lock 0 with direction 1 (over range) moves the tank code up by one; code 111 is the highest-frequency band.
- R7: A downward step requested at code 000 raises fail and leaves the code at 000.
- R8: An upward step requested at code 111 raises fail and leaves the code at 111.
- R9: A second change of step direction within one search raises fail and keeps the current code. With the default budget one reversal is allowed.
- R10: Done is a single-cycle pulse. After it, the tank code and done stay unchanged whatever the flags do, until the next start.
- R11: Fail stays high with the code held until the next start, and done and fail are never high together.
- R12: Apart from a start load, the tank code changes by exactly one step at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Begin or restart a search |
| init_code_i | input | TANK_W | Starting tank code |
| settle_cycles_i | input | CNT_W | Clock cycles to wait after every tank change |
| lock_i | input | 1 | Synthesizer lock flag |
| over_i | input | 1 | Tuning voltage direction: 1 over range, 0 under range |
| tank_o | output | TANK_W | Selected tank band |
| done_o | output | 1 | One-cycle pulse on lock |
| fail_o | output | 1 | Search failed; held until next start |

## Verification
The hardest case to reach from the ports is a flag sample taken too early. A controller that skips the settle interval still finds the right band on a well-behaved loop. The bench therefore models the synthesizer with a deliberately misleading settling phase: for `settle_cycles_i` cycles after each band change it reports a false lock. Any early sample then ends the search on the wrong band.

The two-reversal failure is also hard to reach with a monotonic loop. It is reached by placing the modelled target frequency between two adjacent bands, which forces the search to bounce between them.

// File: rtl/band_search_pkg.sv
package band_search_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_CHECK,
        ST_LOCKED,
        ST_FAIL
    } srch_state_e;

    typedef enum logic [1:0] {
        DIR_NONE,
        DIR_DOWN,
        DIR_UP
    } step_dir_e;

    typedef enum logic [1:0] {
        ACT_LOCK,
        ACT_DOWN,
        ACT_UP,
        ACT_STOP
    } step_act_e;

endpackage

// File: rtl/band_settle_timer.sv
module band_settle_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] count_i,
    output logic             expired_o
);

    logic [CNT_W-1:0] cnt_q;

    // Load wins over the countdown; the count rests at zero once reached.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= count_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/band_reversal_tracker.sv
module band_reversal_tracker
    import band_search_pkg::*;
#(
    parameter int REV_LIMIT = 1,
    localparam int REV_W = (REV_LIMIT < 1) ? 1 : $clog2(REV_LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             step_i,
    input  step_dir_e        dir_i,
    input  logic             reversal_i,
    output step_dir_e        last_dir_o,
    output logic [REV_W-1:0] rev_cnt_o
);

    localparam logic [REV_W-1:0] REV_MAX = {REV_W{1'b1}};

    step_dir_e        last_dir_q;
    logic [REV_W-1:0] rev_cnt_q;

    // Remembers the direction of the last step and counts turnarounds,
    // saturating so that a long search never wraps the count.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_dir_q <= DIR_NONE;
            rev_cnt_q  <= '0;
        end else if (clear_i) begin
            last_dir_q <= DIR_NONE;
            rev_cnt_q  <= '0;
        end else if (step_i) begin
            last_dir_q <= dir_i;
            if (reversal_i && (rev_cnt_q != REV_MAX)) begin
                rev_cnt_q <= rev_cnt_q + REV_W'(1);
            end
        end
    end

    assign last_dir_o = last_dir_q;
    assign rev_cnt_o  = rev_cnt_q;

endmodule

// File: rtl/band_step_decider.sv
module band_step_decider
    import band_search_pkg::*;
#(
    parameter int TANK_W    = 3,
    parameter int REV_LIMIT = 1,
    localparam int REV_W = (REV_LIMIT < 1) ? 1 : $clog2(REV_LIMIT + 1)
) (
    input  logic              lock_i,
    input  logic              over_i,
    input  logic [TANK_W-1:0] tank_i,
    input  step_dir_e         last_dir_i,
    input  logic [REV_W-1:0]  rev_cnt_i,
    output step_act_e         act_o,
    output step_dir_e         dir_o,
    output logic              reversal_o,
    output logic [TANK_W-1:0] tank_next_o
);

    localparam logic [TANK_W-1:0] TANK_LOW  = '0;
    localparam logic [TANK_W-1:0] TANK_HIGH = {TANK_W{1'b1}};
    localparam logic [REV_W-1:0]  REV_CAP   = REV_W'(REV_LIMIT);

    logic want_up;
    logic at_edge;
    logic rev_over;

    assign want_up    = over_i;
    assign dir_o      = want_up ? DIR_UP : DIR_DOWN;
    assign reversal_o = (last_dir_i != DIR_NONE) && (dir_o != last_dir_i);
    assign at_edge    = want_up ? (tank_i == TANK_HIGH) : (tank_i == TANK_LOW);
    assign rev_over   = reversal_o && (rev_cnt_i >= REV_CAP);

    // Lock takes priority over the direction flag; a move is refused
    // when it would leave the band range or exceed the reversal budget.
    always_comb begin
        tank_next_o = tank_i;
        if (lock_i) begin
            act_o = ACT_LOCK;
        end else if (at_edge || rev_over) begin
            act_o = ACT_STOP;
        end else if (want_up) begin
            act_o       = ACT_UP;
            tank_next_o = tank_i + TANK_W'(1);
        end else begin
            act_o       = ACT_DOWN;
            tank_next_o = tank_i - TANK_W'(1);
        end
    end

endmodule

// File: rtl/vco_band_search.sv
module vco_band_search
    import band_search_pkg::*;
#(
    parameter int TANK_W    = 3,
    parameter int CNT_W     = 16,
    parameter int REV_LIMIT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [TANK_W-1:0] init_code_i,
    input  logic [CNT_W-1:0]  settle_cycles_i,
    input  logic              lock_i,
    input  logic              over_i,
    output logic [TANK_W-1:0] tank_o,
    output logic              done_o,
    output logic              fail_o
);

    localparam int REV_W = (REV_LIMIT < 1) ? 1 : $clog2(REV_LIMIT + 1);

    srch_state_e       state_q;
    srch_state_e       state_d;
    logic [TANK_W-1:0] tank_q;
    logic              done_q;
    logic              fail_q;

    logic              timer_expired;
    logic              timer_load;
    step_act_e         act;
    step_dir_e         step_dir;
    logic              step_rev;
    logic [TANK_W-1:0] tank_next;
    step_dir_e         last_dir;
    logic [REV_W-1:0]  rev_cnt;
    logic              in_check;
    logic              take_step;

    assign in_check   = (state_q == ST_CHECK) && !start_i;
    assign take_step  = in_check && ((act == ACT_UP) || (act == ACT_DOWN));
    assign timer_load = start_i || take_step;

    band_settle_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (timer_load),
        .count_i   (settle_cycles_i),
        .expired_o (timer_expired)
    );

    band_step_decider #(
        .TANK_W    (TANK_W),
        .REV_LIMIT (REV_LIMIT)
    ) u_decider (
        .lock_i      (lock_i),
        .over_i      (over_i),
        .tank_i      (tank_q),
        .last_dir_i  (last_dir),
        .rev_cnt_i   (rev_cnt),
        .act_o       (act),
        .dir_o       (step_dir),
        .reversal_o  (step_rev),
        .tank_next_o (tank_next)
    );

    band_reversal_tracker #(
        .REV_LIMIT (REV_LIMIT)
    ) u_reversal (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (start_i),
        .step_i     (take_step),
        .dir_i      (step_dir),
        .reversal_i (step_rev),
        .last_dir_o (last_dir),
        .rev_cnt_o  (rev_cnt)
    );

    // Next-state logic; a start request overrides every state.
    always_comb begin
        state_d = state_q;
        if (start_i) begin
            state_d = ST_SETTLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_IDLE;
                ST_SETTLE: if (timer_expired) state_d = ST_CHECK;
                ST_CHECK: begin
                    unique case (act)
                        ACT_LOCK: state_d = ST_LOCKED;
                        ACT_STOP: state_d = ST_FAIL;
                        default:  state_d = ST_SETTLE;
                    endcase
                end
                ST_LOCKED: state_d = ST_LOCKED;
                ST_FAIL:   state_d = ST_FAIL;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register: tank code, done pulse and sticky fail.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tank_q <= '0;
            done_q <= 1'b0;
            fail_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start_i) begin
                tank_q <= init_code_i;
                fail_q <= 1'b0;
            end else if (in_check) begin
                unique case (act)
                    ACT_LOCK: done_q <= 1'b1;
                    ACT_STOP: fail_q <= 1'b1;
                    default:  tank_q <= tank_next;
                endcase
            end
        end
    end

    assign tank_o = tank_q;
    assign done_o = done_q;
    assign fail_o = fail_q;

endmodule

// File: rtl/vco_band_search_chk.sv
module vco_band_search_chk #(
    parameter int TANK_W = 3,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [CNT_W-1:0]  settle_cycles_i,
    input logic [TANK_W-1:0] tank_o,
    input logic              done_o,
    input logic              fail_o
);

    localparam logic [CNT_W:0] SINCE_MAX = {(CNT_W+1){1'b1}};

    logic [CNT_W:0]    since_q;
    logic [TANK_W-1:0] prev_tank_q;

    // Counts cycles since the last observed tank change or start request.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q     <= '0;
            prev_tank_q <= '0;
        end else begin
            prev_tank_q <= tank_o;
            if (start_i || (tank_o != prev_tank_q)) begin
                since_q <= '0;
            end else if (since_q != SINCE_MAX) begin
                since_q <= since_q + (CNT_W+1)'(1);
            end
        end
    end

    // R3
    settle_respected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((tank_o != $past(tank_o)) && !$past(start_i) && !$past(start_i, 2))
            |-> (since_q >= {1'b0, settle_cycles_i}));

    // R12
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((tank_o != $past(tank_o)) && !$past(start_i))
            |-> (({1'b0, tank_o} == {1'b0, $past(tank_o)} + (TANK_W+1)'(1)) ||
                 ({1'b0, $past(tank_o)} == {1'b0, tank_o} + (TANK_W+1)'(1))));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10
    locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> $stable(tank_o));

    // R11
    fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_o && !start_i) |=> (fail_o && $stable(tank_o)));

    // R11
    exclusive_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && fail_o));

endmodule

bind vco_band_search vco_band_search_chk #(
    .TANK_W (TANK_W),
    .CNT_W  (CNT_W)
) u_band_search_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .start_i         (start_i),
    .settle_cycles_i (settle_cycles_i),
    .tank_o          (tank_o),
    .done_o          (done_o),
    .fail_o          (fail_o)
);

// File: tb/tb_vco_band_search.sv
`timescale 1ns/1ps
module tb_vco_band_search;

    typedef struct {
        bit         fail;
        logic [2:0] code;
        string      tag;
    } exp_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  init_code_i = '0;
    logic [15:0] settle_cycles_i = '0;
    logic        lock_i = 1'b0;
    logic        over_i = 1'b0;
    logic [2:0]  tank_o;
    logic        done_o;
    logic        fail_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    exp_item_t sb[$];

    // Plant model: target band given as twice its code; false lock while settling.
    int         tx2 = 0;
    int         since = 0;
    logic [2:0] prev_tank = '0;
    bit         force_on = 0;
    bit         force_lock = 0;
    bit         force_over = 0;
    bit         done_prev = 0;
    bit         fail_prev = 0;

    always #2.5 clk = ~clk;

    vco_band_search dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .start_i         (start_i),
        .init_code_i     (init_code_i),
        .settle_cycles_i (settle_cycles_i),
        .lock_i          (lock_i),
        .over_i          (over_i),
        .tank_o          (tank_o),
        .done_o          (done_o),
        .fail_o          (fail_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (tank_o != prev_tank) since = 0;
        else if (since < 100000) since = since + 1;
        prev_tank = tank_o;
        if (force_on) begin
            lock_i <= force_lock;
            over_i <= force_over;
        end else if (since < int'(settle_cycles_i)) begin
            lock_i <= 1'b1;
            over_i <= 1'b0;
        end else begin
            lock_i <= (2 * int'(tank_o) == tx2);
            over_i <= (2 * int'(tank_o) < tx2);
        end
    end

    // Monitor: pops the scoreboard whenever a result appears.
    always @(negedge clk) begin
        if (rst_n) begin
            if (done_o && done_prev) check("R10 done width", 2, 1);
            if (done_o || (fail_o && !fail_prev)) begin
                if (sb.size() == 0) begin
                    check("R2 unexpected result", 1, 0);
                end else begin
                    exp_item_t e;
                    e = sb.pop_front();
                    check({e.tag, " outcome"}, int'(fail_o), int'(e.fail));
                    check({e.tag, " code"}, int'(tank_o), int'(e.code));
                end
            end
        end
        done_prev = done_o;
        fail_prev = fail_o;
    end

    task automatic pulse_start(input logic [2:0] init, input int t2, input int settle);
        @(negedge clk);
        tx2 = t2;
        settle_cycles_i = 16'(settle);
        init_code_i = init;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R2 load", int'(tank_o), int'(init));
        check("R2 fail cleared", int'(fail_o), 0);
    endtask

    task automatic run(input logic [2:0] init, input int t2, input int settle,
                       input bit ef, input logic [2:0] ec, input string tag);
        exp_item_t e;
        e.fail = ef;
        e.code = ec;
        e.tag  = tag;
        sb.push_back(e);
        pulse_start(init, t2, settle);
        while (sb.size() != 0) @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 tank", int'(tank_o), 0);
        check("R1 done", int'(done_o), 0);
        check("R1 fail", int'(fail_o), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 idle tank", int'(tank_o), 0);

        // R4: lock at the first sample keeps the starting band
        run(3'd4, 8, 5, 0, 3'd4, "R4 immediate lock");
        // R10: flags demanding a move after lock have no effect
        force_on = 1; force_lock = 0; force_over = 1;
        repeat (30) @(negedge clk);
        check("R10 tank held", int'(tank_o), 4);
        check("R10 no done", int'(done_o), 0);
        check("R10 no fail", int'(fail_o), 0);
        force_on = 0;

        // R6 and R3: climb from 1 to 5 with false lock while settling
        run(3'd1, 10, 8, 0, 3'd5, "R6 R3 upward search");
        // R5: descend from 6 to 2
        run(3'd6, 4, 3, 0, 3'd2, "R5 downward search");
        // R7: target below the lowest band
        run(3'd2, -2, 2, 1, 3'd0, "R7 low boundary");
        // R8: target above the highest band, zero settle
        run(3'd5, 20, 0, 1, 3'd7, "R8 high boundary");
        // R11: fail and code held while flags still ask to climb
        repeat (30) @(negedge clk);
        check("R11 fail held", int'(fail_o), 1);
        check("R11 code held", int'(tank_o), 7);
        check("R11 no done", int'(done_o), 0);

        // R9: target between bands 3 and 4 forces repeated turnarounds
        run(3'd3, 7, 4, 1, 3'd3, "R9 second reversal");

        // R2: restart during a slow search; only the second one reports
        pulse_start(3'd0, 14, 40);
        repeat (20) @(negedge clk);
        check("R2 first search still running", int'(done_o | fail_o), 0);
        run(3'd6, 12, 3, 0, 3'd6, "R2 restart result");
        repeat (10) @(negedge clk);
        check("R2 no stray result", sb.size(), 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
        $finish;
    end

endmodule